// File: doc/BRIEF.md
# Timer Interrupt Flag Controller

This block keeps the 8-bit interrupt flag register of a 16-bit timer/counter with up to four compare/capture channels. Strobes from the counter core set the flags. The active operating mode decides which event sets a flag and which access clears it. The block then drives a per-flag interrupt request, gated by an enable mask, and DMA request lines for the channel flags and the overflow flag.

Several agents can clear a flag: a CPU write of one to its bit, an interrupt-vector acknowledge, a CPU read of a channel's capture register, or a DMA access to the register that goes with the flag. Each flag is a single register bit. If a set event and a clear event reach the same flag in the same cycle, the set is kept, so no event is lost. Every flag changes on the clock edge that samples its event, which means an event is visible at the outputs in the next cycle.

Top module: `tmr_irq_flags`

## Requirements
- R1: After reset, `flags`, `irq_req`, `dma_req_ch` and `dma_req_ovf` are all zero.
- R2: Bits 3 and 2 of `flags` always read zero. A register write with ones in those bits, or with zeros anywhere, changes no flag.
- R3: In modes 0 (compare), 1 (frequency/PWM) and 3 (quadrature decode), `cmp_match[i]` sets `flags[4+i]` one cycle later, and `ack_ch[i]` clears it. Channel A is bit 4 and channel D is bit 7.
- R4: In mode 2 (capture), `cap_valid[i]` sets `flags[4+i]` and `cap_rd[i]` clears it. In this mode `ack_ch[i]` and `cmp_match[i]` have no effect.
- R5: A cycle with `reg_wr` high clears every flag whose bit in `reg_wdata` is one.
- R6: `dma_req_ch[i]` equals `flags[4+i]`, and `dma_ch_acc[i]` clears that flag.
- R7: The error flag is `flags[1]`. It is set by `fault_det` in mode 1, by any `cap_ovrun` bit in mode 2, and by `bad_index` in mode 3. None of these sets it in mode 0. `ack_err` clears it.
- R8: The overflow flag is `flags[0]`. It is set by `hit_top` when `ovf_sel_bottom` is 0 and by `hit_bottom` when `ovf_sel_bottom` is 1. `ack_ovf` or `dma_cnt_wr` clears it, and `dma_req_ovf` equals it.
- R9: With parameter `HAS_FAULT` = 0, `fault_det` never sets the error flag.
- R10: A set event and a clear event on the same flag in the same cycle leave the flag set.
- R11: `irq_req` equals `flags & irq_en` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 2 | Operating mode: 0 compare, 1 frequency/PWM, 2 capture, 3 quadrature decode |
| ovf_sel_bottom | input | 1 | 1: overflow flag follows BOTTOM, 0: follows TOP |
| cmp_match | input | NUM_CH | Per-channel compare match strobes |
| cap_valid | input | NUM_CH | Per-channel capture buffer holds valid data |
| cap_ovrun | input | NUM_CH | Per-channel capture buffer overflow strobes |
| hit_top | input | 1 | Counter reached TOP |
| hit_bottom | input | 1 | Counter reached BOTTOM |
| fault_det | input | 1 | Fault detected by the waveform protection logic |
| bad_index | input | 1 | Incorrect index pulse during quadrature decoding |
| reg_wr | input | 1 | CPU write to the flag register |
| reg_wdata | input | 8 | CPU write data (ones clear flags) |
| cap_rd | input | NUM_CH | CPU read of a channel's capture register |
| ack_ch | input | NUM_CH | Per-channel interrupt vector acknowledge |
| ack_err | input | 1 | Error interrupt acknowledge |
| ack_ovf | input | 1 | Overflow interrupt acknowledge |
| dma_ch_acc | input | NUM_CH | DMA access to a channel's compare register or its buffer |
| dma_cnt_wr | input | 1 | DMA write to the count, period or period-buffer register |
| irq_en | input | 8 | Per-bit interrupt enable mask |
| flags | output | 8 | Flag register contents |
| irq_req | output | 8 | Per-flag interrupt requests |
| dma_req_ch | output | NUM_CH | Per-channel DMA requests |
| dma_req_ovf | output | 1 | Overflow DMA request |

## Verification
The hardest situation to reach is a flag that receives a set and one or more clears in the same cycle while the mode selects which of those events count. One example is a capture-mode flag whose buffer is still valid when its register is read and its vector is acknowledged. Directed steps create each such collision on purpose: set plus acknowledge on the overflow flag, and valid plus read on a capture channel. Random stimulus then drives every strobe at once with sparse probabilities and picks a new mode almost every cycle, so that mode changes land on flags that are already set. A second instance built without fault detection runs on the same inputs during the random phase.

// File: rtl/tif_pkg.sv
package tif_pkg;
   typedef enum logic [1:0] {
      TIF_CMP  = 2'd0,
      TIF_WAVE = 2'd1,
      TIF_CAPT = 2'd2,
      TIF_QDEC = 2'd3
   } tif_mode_e;

   localparam int TIF_REG_W   = 8;
   localparam int TIF_MAX_CH  = 4;
   localparam int TIF_CH_LSB  = 4;
   localparam int TIF_ERR_BIT = 1;
   localparam int TIF_OVF_BIT = 0;
endpackage

// File: rtl/tif_flag_cell.sv
module tif_flag_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic set_ev,
   input  logic clr_ev,
   output logic q
);
   // set has priority over clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= set_ev | (q & ~clr_ev);
   end
endmodule

// File: rtl/tif_chan_ctl.sv
module tif_chan_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic capt_mode,
   input  logic cmp_hit,
   input  logic buf_valid,
   input  logic cap_read,
   input  logic vec_ack,
   input  logic dma_touch,
   input  logic sw_clr,
   output logic flag
);
   logic set_ev, clr_ev;

   always_comb begin
      if (capt_mode) begin
         set_ev = buf_valid;
         clr_ev = cap_read;
      end else begin
         set_ev = cmp_hit;
         clr_ev = vec_ack;
      end
      clr_ev = clr_ev | dma_touch | sw_clr;
   end

   tif_flag_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_ev (set_ev),
      .clr_ev (clr_ev),
      .q      (flag)
   );
endmodule

// File: rtl/tif_err_ctl.sv
module tif_err_ctl
   import tif_pkg::*;
#(
   parameter int NUM_CH    = 4,
   parameter bit HAS_FAULT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  tif_mode_e         mode,
   input  logic              fault_det,
   input  logic [NUM_CH-1:0] cap_ovrun,
   input  logic              bad_index,
   input  logic              vec_ack,
   input  logic              sw_clr,
   output logic              flag
);
   logic fault_term, set_ev;

   generate
      if (HAS_FAULT) begin : g_fault
         assign fault_term = (mode == TIF_WAVE) & fault_det;
      end else begin : g_nofault
         logic unused_fault;
         assign unused_fault = fault_det;
         assign fault_term   = 1'b0;
      end
   endgenerate

   assign set_ev = fault_term
                 | ((mode == TIF_CAPT) & (|cap_ovrun))
                 | ((mode == TIF_QDEC) & bad_index);

   tif_flag_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_ev (set_ev),
      .clr_ev (vec_ack | sw_clr),
      .q      (flag)
   );
endmodule

// File: rtl/tif_ovf_ctl.sv
module tif_ovf_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic sel_bottom,
   input  logic hit_top,
   input  logic hit_bottom,
   input  logic vec_ack,
   input  logic dma_wr,
   input  logic sw_clr,
   output logic flag
);
   logic set_ev;
   assign set_ev = sel_bottom ? hit_bottom : hit_top;

   tif_flag_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_ev (set_ev),
      .clr_ev (vec_ack | dma_wr | sw_clr),
      .q      (flag)
   );
endmodule

// File: rtl/tmr_irq_flags.sv
module tmr_irq_flags
   import tif_pkg::*;
#(
   parameter int NUM_CH    = 4,
   parameter bit HAS_FAULT = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [1:0]           mode,
   input  logic                 ovf_sel_bottom,
   input  logic [NUM_CH-1:0]    cmp_match,
   input  logic [NUM_CH-1:0]    cap_valid,
   input  logic [NUM_CH-1:0]    cap_ovrun,
   input  logic                 hit_top,
   input  logic                 hit_bottom,
   input  logic                 fault_det,
   input  logic                 bad_index,
   input  logic                 reg_wr,
   input  logic [TIF_REG_W-1:0] reg_wdata,
   input  logic [NUM_CH-1:0]    cap_rd,
   input  logic [NUM_CH-1:0]    ack_ch,
   input  logic                 ack_err,
   input  logic                 ack_ovf,
   input  logic [NUM_CH-1:0]    dma_ch_acc,
   input  logic                 dma_cnt_wr,
   input  logic [TIF_REG_W-1:0] irq_en,
   output logic [TIF_REG_W-1:0] flags,
   output logic [TIF_REG_W-1:0] irq_req,
   output logic [NUM_CH-1:0]    dma_req_ch,
   output logic                 dma_req_ovf
);
   localparam int RSV_LO = TIF_ERR_BIT + 1;
   localparam int RSV_HI = TIF_CH_LSB - 1;

   generate
      if (NUM_CH < 1 || NUM_CH > TIF_MAX_CH) begin : g_bad_ch
         $error("tmr_irq_flags: NUM_CH must be 1..4");
      end
   endgenerate

   tif_mode_e              mode_e;
   logic                   capt_mode;
   logic [TIF_REG_W-1:0]   wr_ones;
   logic [TIF_MAX_CH-1:0]  ch_flag;
   logic                   err_flag, ovf_flag;
   logic                   unused_rsvd;

   assign mode_e      = tif_mode_e'(mode);
   assign capt_mode   = (mode_e == TIF_CAPT);
   assign wr_ones     = reg_wr ? reg_wdata : '0;
   assign unused_rsvd = ^wr_ones[RSV_HI:RSV_LO];

   generate
      for (genvar i = 0; i < TIF_MAX_CH; i++) begin : g_ch
         if (i < NUM_CH) begin : g_live
            tif_chan_ctl u_chan (
               .clk       (clk),
               .rst_n     (rst_n),
               .capt_mode (capt_mode),
               .cmp_hit   (cmp_match[i]),
               .buf_valid (cap_valid[i]),
               .cap_read  (cap_rd[i]),
               .vec_ack   (ack_ch[i]),
               .dma_touch (dma_ch_acc[i]),
               .sw_clr    (wr_ones[TIF_CH_LSB+i]),
               .flag      (ch_flag[i])
            );
         end else begin : g_absent
            assign ch_flag[i] = 1'b0;
         end
      end
   endgenerate

   tif_err_ctl #(.NUM_CH(NUM_CH), .HAS_FAULT(HAS_FAULT)) u_err (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode      (mode_e),
      .fault_det (fault_det),
      .cap_ovrun (cap_ovrun),
      .bad_index (bad_index),
      .vec_ack   (ack_err),
      .sw_clr    (wr_ones[TIF_ERR_BIT]),
      .flag      (err_flag)
   );

   tif_ovf_ctl u_ovf (
      .clk        (clk),
      .rst_n      (rst_n),
      .sel_bottom (ovf_sel_bottom),
      .hit_top    (hit_top),
      .hit_bottom (hit_bottom),
      .vec_ack    (ack_ovf),
      .dma_wr     (dma_cnt_wr),
      .sw_clr     (wr_ones[TIF_OVF_BIT]),
      .flag       (ovf_flag)
   );

   always_comb begin
      flags = '0;
      flags[TIF_CH_LSB +: TIF_MAX_CH] = ch_flag;
      flags[TIF_ERR_BIT]              = err_flag;
      flags[TIF_OVF_BIT]              = ovf_flag;
   end

   assign irq_req     = flags & irq_en;
   assign dma_req_ch  = ch_flag[NUM_CH-1:0];
   assign dma_req_ovf = ovf_flag;
endmodule

// File: rtl/tif_checker.sv
module tif_checker
   import tif_pkg::*;
#(
   parameter int NUM_CH    = 4,
   parameter bit HAS_FAULT = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        mode,
   input logic              ovf_sel_bottom,
   input logic [NUM_CH-1:0] cmp_match,
   input logic [NUM_CH-1:0] cap_valid,
   input logic [NUM_CH-1:0] cap_rd,
   input logic [NUM_CH-1:0] dma_ch_acc,
   input logic              hit_top,
   input logic              hit_bottom,
   input logic              fault_det,
   input logic              ack_ovf,
   input logic              reg_wr,
   input logic [7:0]        reg_wdata,
   input logic [7:0]        irq_en,
   input logic [7:0]        flags,
   input logic [7:0]        irq_req,
   input logic [NUM_CH-1:0] dma_req_ch,
   input logic              dma_req_ovf
);
   logic ovf_set;
   assign ovf_set = ovf_sel_bottom ? hit_bottom : hit_top;

   // R2
   a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_wdata[3:2] != 2'b00) |=> flags[3:2] == 2'b00);
   // R11
   a_r11_irq_mask: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req == (flags & irq_en));
   // R8
   a_r8_ovf_dma: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req_ovf == flags[0]);
   a_r8_ovf_sets: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_set |=> flags[0]);
   a_r8_ovf_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_ovf && !ovf_set) |=> !flags[0]);
   // R5
   a_r5_err_wr_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_wdata[1] && mode == TIF_CMP) |=> !flags[1]);
   a_r5_ovf_wr_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_wdata[0] && !ovf_set) |=> !flags[0]);

   generate
      if (HAS_FAULT) begin : g_f
         // R7
         a_r7_fault_sets: assert property (@(posedge clk) disable iff (!rst_n)
            (mode == TIF_WAVE && fault_det) |=> flags[1]);
      end else begin : g_nf
         // R9
         a_r9_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
            (mode == TIF_WAVE && fault_det && !flags[1]) |=> !flags[1]);
      end

      for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
         // R3
         a_r3_cmp_sets: assert property (@(posedge clk) disable iff (!rst_n)
            (mode != TIF_CAPT && cmp_match[i]) |=> flags[4+i]);
         // R4
         a_r4_ack_ignored: assert property (@(posedge clk) disable iff (!rst_n)
            (mode == TIF_CAPT && flags[4+i] && !cap_rd[i] && !dma_ch_acc[i]
             && !(reg_wr && reg_wdata[4+i])) |=> flags[4+i]);
         // R6
         a_r6_dma_req: assert property (@(posedge clk) disable iff (!rst_n)
            dma_req_ch[i] == flags[4+i]);
         // R10
         a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (mode == TIF_CAPT && cap_valid[i] && cap_rd[i]) |=> flags[4+i]);
      end
   endgenerate
endmodule

bind tmr_irq_flags tif_checker #(.NUM_CH(NUM_CH), .HAS_FAULT(HAS_FAULT)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .mode           (mode),
   .ovf_sel_bottom (ovf_sel_bottom),
   .cmp_match      (cmp_match),
   .cap_valid      (cap_valid),
   .cap_rd         (cap_rd),
   .dma_ch_acc     (dma_ch_acc),
   .hit_top        (hit_top),
   .hit_bottom     (hit_bottom),
   .fault_det      (fault_det),
   .ack_ovf        (ack_ovf),
   .reg_wr         (reg_wr),
   .reg_wdata      (reg_wdata),
   .irq_en         (irq_en),
   .flags          (flags),
   .irq_req        (irq_req),
   .dma_req_ch     (dma_req_ch),
   .dma_req_ovf    (dma_req_ovf)
);

// File: tb/tmr_irq_flags_test.sv
`timescale 1ns/1ps
module tmr_irq_flags_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] mode = 2'd0;
   logic       ovf_sel_bottom = 1'b0;
   logic [3:0] cmp_match = '0, cap_valid = '0, cap_ovrun = '0;
   logic       hit_top = 1'b0, hit_bottom = 1'b0, fault_det = 1'b0, bad_index = 1'b0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [3:0] cap_rd = '0, ack_ch = '0, dma_ch_acc = '0;
   logic       ack_err = 1'b0, ack_ovf = 1'b0, dma_cnt_wr = 1'b0;
   logic [7:0] irq_en = '0;
   logic [7:0] flags, irq_req, flags_nf, irq_nf;
   logic [3:0] dma_req_ch, dma_nf;
   logic       dma_req_ovf, dovf_nf;

   int n_chk = 0, n_err = 0;
   bit done = 1'b0;
   logic [7:0] exp_m = '0, exp_n = '0;

   always #10 clk = ~clk;

   tmr_irq_flags #(.NUM_CH(4), .HAS_FAULT(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .mode(mode), .ovf_sel_bottom(ovf_sel_bottom),
      .cmp_match(cmp_match), .cap_valid(cap_valid), .cap_ovrun(cap_ovrun),
      .hit_top(hit_top), .hit_bottom(hit_bottom), .fault_det(fault_det),
      .bad_index(bad_index), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .cap_rd(cap_rd), .ack_ch(ack_ch), .ack_err(ack_err), .ack_ovf(ack_ovf),
      .dma_ch_acc(dma_ch_acc), .dma_cnt_wr(dma_cnt_wr), .irq_en(irq_en),
      .flags(flags), .irq_req(irq_req), .dma_req_ch(dma_req_ch),
      .dma_req_ovf(dma_req_ovf));

   tmr_irq_flags #(.NUM_CH(4), .HAS_FAULT(1'b0)) uut_nf (
      .clk(clk), .rst_n(rst_n), .mode(mode), .ovf_sel_bottom(ovf_sel_bottom),
      .cmp_match(cmp_match), .cap_valid(cap_valid), .cap_ovrun(cap_ovrun),
      .hit_top(hit_top), .hit_bottom(hit_bottom), .fault_det(fault_det),
      .bad_index(bad_index), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .cap_rd(cap_rd), .ack_ch(ack_ch), .ack_err(ack_err), .ack_ovf(ack_ovf),
      .dma_ch_acc(dma_ch_acc), .dma_cnt_wr(dma_cnt_wr), .irq_en(irq_en),
      .flags(flags_nf), .irq_req(irq_nf), .dma_req_ch(dma_nf),
      .dma_req_ovf(dovf_nf));

   // next flag value from the requirements (R2..R10)
   function automatic logic [7:0] next_flags(input logic [7:0] cur, input bit hf);
      logic [7:0] nx, w;
      logic s, c;
      w  = reg_wr ? reg_wdata : 8'h00;
      nx = 8'h00;
      for (int i = 0; i < 4; i++) begin
         if (mode == 2'd2) begin s = cap_valid[i]; c = cap_rd[i]; end
         else              begin s = cmp_match[i]; c = ack_ch[i]; end
         c = c | w[4+i] | dma_ch_acc[i];
         nx[4+i] = s | (cur[4+i] & ~c);
      end
      s = (mode == 2'd1 && hf && fault_det) || (mode == 2'd2 && cap_ovrun != 4'h0)
          || (mode == 2'd3 && bad_index);
      nx[1] = s | (cur[1] & ~(ack_err | w[1]));
      s = ovf_sel_bottom ? hit_bottom : hit_top;
      nx[0] = s | (cur[0] & ~(ack_ovf | w[0] | dma_cnt_wr));
      return nx;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic quiet();
      cmp_match = '0; cap_valid = '0; cap_ovrun = '0; hit_top = 0; hit_bottom = 0;
      fault_det = 0; bad_index = 0; reg_wr = 0; reg_wdata = '0; cap_rd = '0;
      ack_ch = '0; ack_err = 0; ack_ovf = 0; dma_ch_acc = '0; dma_cnt_wr = 0;
   endtask

   // one clock: model update, then sample at the following falling edge
   task automatic tick();
      exp_m = next_flags(exp_m, 1'b1);
      exp_n = next_flags(exp_n, 1'b0);
      @(posedge clk);
      @(negedge clk);
      chk("model main", {flags, irq_req, dma_req_ch, 3'b000, dma_req_ovf},
          {exp_m, exp_m & irq_en, exp_m[7:4], 3'b000, exp_m[0]});
      chk("model R9 variant", {flags_nf, irq_nf, dma_nf, 3'b000, dovf_nf},
          {exp_n, exp_n & irq_en, exp_n[7:4], 3'b000, exp_n[0]});
      quiet();
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240517));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 flags", flags, 8'h00);
      chk("R1 irq", irq_req, 8'h00);
      chk("R1 dma", {dma_req_ch, dma_req_ovf}, 5'h00);

      irq_en = 8'hFF;
      mode = 2'd0; cmp_match = 4'b0101; tick();
      chk("R3 compare sets", flags, 8'h50);
      chk("R11 irq follows", irq_req, 8'h50);
      ack_ch = 4'b0001; tick();
      chk("R3 ack clears A", flags, 8'h40);
      mode = 2'd3; cmp_match = 4'b0010; tick();
      chk("R3 qdec compare", flags, 8'h60);
      ack_ch = 4'b0010; tick();

      reg_wr = 1; reg_wdata = 8'h0C; tick();
      chk("R2 reserved write", flags, 8'h40);
      reg_wr = 1; reg_wdata = 8'h00; tick();
      chk("R2 zero write", flags, 8'h40);
      reg_wr = 1; reg_wdata = 8'h40; tick();
      chk("R5 write one", flags, 8'h00);

      mode = 2'd2; cap_valid = 4'b0010; tick();
      chk("R4 valid sets", flags, 8'h20);
      ack_ch = 4'b1111; tick();
      chk("R4 ack ignored", flags, 8'h20);
      cmp_match = 4'b1111; tick();
      chk("R4 compare ignored", flags, 8'h20);
      cap_rd = 4'b0010; tick();
      chk("R4 read clears", flags, 8'h00);
      cap_valid = 4'b0001; tick();
      cap_valid = 4'b0001; cap_rd = 4'b0001; ack_ch = 4'b0001; tick();
      chk("R10 valid beats read", flags, 8'h10);
      cap_rd = 4'b0001; tick();

      mode = 2'd0; cmp_match = 4'b1000; tick();
      chk("R6 dma request", {dma_req_ch, flags}, {4'b1000, 8'h80});
      dma_ch_acc = 4'b1000; tick();
      chk("R6 dma clears", {dma_req_ch, flags}, {4'b0000, 8'h00});

      mode = 2'd1; fault_det = 1; tick();
      chk("R7 fault sets", flags, 8'h02);
      chk("R9 no fault variant", flags_nf, 8'h00);
      ack_err = 1; tick();
      chk("R7 ack clears", flags, 8'h00);
      mode = 2'd2; cap_ovrun = 4'b0100; tick();
      chk("R7 overrun sets", flags, 8'h02);
      reg_wr = 1; reg_wdata = 8'h02; tick();
      mode = 2'd3; bad_index = 1; tick();
      chk("R7 bad index sets", flags, 8'h02);
      ack_err = 1; tick();
      mode = 2'd0; fault_det = 1; cap_ovrun = 4'hF; bad_index = 1; tick();
      chk("R7 compare mode no error", flags, 8'h00);

      ovf_sel_bottom = 0; hit_bottom = 1; tick();
      chk("R8 bottom ignored", flags, 8'h00);
      hit_top = 1; tick();
      chk("R8 top sets", {dma_req_ovf, flags}, {1'b1, 8'h01});
      dma_cnt_wr = 1; tick();
      chk("R8 dma write clears", {dma_req_ovf, flags}, {1'b0, 8'h00});
      ovf_sel_bottom = 1; hit_bottom = 1; tick();
      chk("R8 bottom sets", flags, 8'h01);
      hit_bottom = 1; ack_ovf = 1; tick();
      chk("R10 overflow set wins", flags, 8'h01);
      ack_ovf = 1; tick();
      chk("R8 ack clears", flags, 8'h00);

      mode = 2'd0; cmp_match = 4'b0010; hit_bottom = 1; tick();
      irq_en = 8'h01; #1;
      chk("R11 mask low", irq_req, 8'h01);
      irq_en = 8'h20; #1;
      chk("R11 mask high", irq_req, 8'h20);
      @(negedge clk);

      for (int k = 0; k < 4000; k++) begin
         mode = 2'($urandom);
         ovf_sel_bottom = (($urandom % 16) == 0) ? ~ovf_sel_bottom : ovf_sel_bottom;
         cmp_match  = 4'($urandom & $urandom);
         cap_valid  = 4'($urandom & $urandom);
         cap_ovrun  = 4'($urandom & $urandom & $urandom);
         hit_top    = ($urandom % 5) == 0;
         hit_bottom = ($urandom % 5) == 0;
         fault_det  = ($urandom % 6) == 0;
         bad_index  = ($urandom % 6) == 0;
         reg_wr     = ($urandom % 4) == 0;
         reg_wdata  = 8'($urandom);
         cap_rd     = 4'($urandom & $urandom);
         ack_ch     = 4'($urandom & $urandom);
         ack_err    = ($urandom % 4) == 0;
         ack_ovf    = ($urandom % 4) == 0;
         dma_ch_acc = 4'($urandom & $urandom & $urandom);
         dma_cnt_wr = ($urandom % 8) == 0;
         irq_en     = 8'($urandom);
         tick();
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule